// File: doc/BRIEF.md
# Shared-Noise String Equality Verifier

This block decides whether a locally held N-bit string is very probably identical to a string held at a remote side, while the two sides exchange one sign bit per step instead of the strings. Both sides hold the same bank of 2N pseudo-random ±1 reference streams, one for each position and possible bit value. Each step, a side picks from every position the stream that matches its own bit there. It multiplies the picked values into a single ±1 sample. A product of ±1 values is the XOR of their sign bits.

One instance runs one side of the exchange. It presents its own sample on `tx_sample` for the remote side and compares the remote sample on `rx_sample` against its own on every accepted step. If the strings differ in any position, the two product sequences are independent, so a mismatch soon appears. The first mismatch ends the run with a sticky `differ` flag. If the programmed number of steps passes without a mismatch, the block reports `equal`. With 83 steps, a false match has a probability of about 2^-83, roughly 10^-25. A `start` pulse loads the string, reseeds every generator and clears the run state.

Top module: `noise_hash_verifier`

## Requirements
- R1: After synchronous reset, `busy`, `differ`, `equal` and `done` are 0 and `steps_done` is 0.
- R2: A cycle with `start` high loads `loc_str`, reseeds all streams and takes priority over a step. In the following cycle `busy` is 1, `differ`, `equal` and `done` are 0 and `steps_done` is 0.
- R3: Stream k = 2*i + v serves position i with bit value v. At start it is seeded with `seed` XOR the low W bits of (k+1)*0x9E3779B9, and an all-zero result becomes 1. On each accepted step it shifts right, and if the bit shifted out was 1 it is XORed with TAPS (0xB400 for W=16). Its sign bit is state bit 0, where 1 means -1.
- R4: While `busy` is 1, `tx_sample` is the XOR, over all positions i, of the sign bit of stream 2*i + `loaded_str[i]`, taken from the current stream states.
- R5: A step is accepted when `busy` and `step_en` are 1 and `start` is 0. If `rx_sample` differs from `tx_sample` in that cycle, then in the next cycle `differ` is 1, `busy` is 0 and `done` is 1 for exactly one cycle.
- R6: Each accepted step adds one to `steps_done`, including a failing one. If the step that brings `steps_done` to the target has no mismatch, then in the next cycle `equal` is 1, `busy` is 0 and `done` is 1 for one cycle.
- R7: `differ` and `equal` are never 1 together, and each stays set until the next start.
- R8: While `busy` is 0, `step_en` and `rx_sample` have no effect: `steps_done`, the flags and `tx_sample` hold their values.
- R9: With identical strings at both sides, the same seed and the same accepted steps, the run ends with `equal`.
- R10: The target is taken from `num_steps` at start. A value of 0 selects the default of 83 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load string, reseed streams, clear run state |
| loc_str | input | N_BITS | Local string, captured at start |
| seed | input | LFSR_W | Shared seed, captured at start |
| num_steps | input | CNT_W | Step target captured at start; 0 selects the default |
| step_en | input | 1 | A remote sample is present this cycle |
| rx_sample | input | 1 | Remote sign bit (1 = -1) |
| tx_sample | output | 1 | Local sign bit for the current step |
| busy | output | 1 | A run is in progress |
| differ | output | 1 | Sticky: a mismatch was seen |
| equal | output | 1 | Sticky: the target was reached with no mismatch |
| done | output | 1 | One-cycle pulse when a run ends |
| steps_done | output | CNT_W | Accepted steps in the current run |

## Verification
The assertions assume that `num_steps` is captured as a nonzero target or as 0 for the default, so a live run never has a zero target. They also assume that `start` is the only way out of a finished run. The stimulus applies `start` only at chosen points, including once in the middle of a run. It drives `rx_sample` from a behavioural model of the remote side. Mismatches come from a one-bit string difference and from a deliberately flipped sample. Idle cycles with `step_en` high test that such input is ignored.

// File: rtl/nhv_pkg.sv
package nhv_pkg;
  localparam logic [31:0] MIX_CONST = 32'h9E3779B9;

  // per-stream seed offset, stream index k
  function automatic logic [31:0] stream_mix(input int unsigned k);
    return (k + 1) * MIX_CONST;
  endfunction
endpackage

// File: rtl/nhv_ref_bank.sv
module nhv_ref_bank #(
  parameter int N_BITS = 8,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reseed,
  input  logic                  advance,
  input  logic [LFSR_W-1:0]     seed,
  output logic [2*N_BITS-1:0]   ref_sign
);
  localparam int N_STREAMS = 2 * N_BITS;

  for (genvar k = 0; k < N_STREAMS; k++) begin : g_stream
    logic [LFSR_W-1:0] state_q;
    logic [LFSR_W-1:0] init_val;
    logic [LFSR_W-1:0] mixed;
    logic [31:0]       mix_word;

    assign mix_word = nhv_pkg::stream_mix(k);
    assign mixed    = seed ^ mix_word[LFSR_W-1:0];
    assign init_val = (mixed == '0) ? LFSR_W'(1) : mixed;

    always_ff @(posedge clk) begin
      if (rst) begin
        state_q <= LFSR_W'(1);
      end else if (reseed) begin
        state_q <= init_val;
      end else if (advance) begin
        state_q <= (state_q >> 1) ^ (state_q[0] ? TAPS : '0);
      end
    end

    assign ref_sign[k] = state_q[0];
  end
endmodule

// File: rtl/nhv_product.sv
module nhv_product #(
  parameter int N_BITS = 8
) (
  input  logic [2*N_BITS-1:0] ref_sign,
  input  logic [N_BITS-1:0]   str,
  output logic                sample
);
  always_comb begin
    sample = 1'b0;
    for (int i = 0; i < N_BITS; i++) begin
      sample = sample ^ ref_sign[2*i + int'(str[i])];
    end
  end
endmodule

// File: rtl/nhv_ctrl.sv
module nhv_ctrl #(
  parameter int CNT_W     = 8,
  parameter int DEF_STEPS = 83
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] num_steps,
  input  logic             step_en,
  input  logic             rx_sample,
  input  logic             local_sample,
  output logic             step_fire,
  output logic             busy,
  output logic             differ,
  output logic             equal,
  output logic             done,
  output logic [CNT_W-1:0] steps_done,
  output logic [CNT_W-1:0] target
);
  localparam logic [CNT_W-1:0] DEF_TGT = CNT_W'(DEF_STEPS);

  logic [CNT_W-1:0] cnt_next;
  logic             mismatch;

  assign step_fire = busy && step_en && !start;
  assign cnt_next  = steps_done + CNT_W'(1);
  assign mismatch  = rx_sample ^ local_sample;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      differ     <= 1'b0;
      equal      <= 1'b0;
      done       <= 1'b0;
      steps_done <= '0;
      target     <= DEF_TGT;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy       <= 1'b1;
        differ     <= 1'b0;
        equal      <= 1'b0;
        steps_done <= '0;
        target     <= (num_steps == '0) ? DEF_TGT : num_steps;
      end else if (step_fire) begin
        steps_done <= cnt_next;
        if (mismatch) begin
          differ <= 1'b1;
          busy   <= 1'b0;
          done   <= 1'b1;
        end else if (cnt_next == target) begin
          equal <= 1'b1;
          busy  <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/noise_hash_verifier.sv
module noise_hash_verifier #(
  parameter int N_BITS    = 8,
  parameter int LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] TAPS = 16'hB400,
  parameter int CNT_W     = 8,
  parameter int DEF_STEPS = 83
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [N_BITS-1:0] loc_str,
  input  logic [LFSR_W-1:0] seed,
  input  logic [CNT_W-1:0]  num_steps,
  input  logic              step_en,
  input  logic              rx_sample,
  output logic              tx_sample,
  output logic              busy,
  output logic              differ,
  output logic              equal,
  output logic              done,
  output logic [CNT_W-1:0]  steps_done
);
  logic [N_BITS-1:0]   str_q;
  logic [2*N_BITS-1:0] ref_sign;
  logic                step_fire;
  logic [CNT_W-1:0]    target_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      str_q <= '0;
    end else if (start) begin
      str_q <= loc_str;
    end
  end

  nhv_ref_bank #(.N_BITS(N_BITS), .LFSR_W(LFSR_W), .TAPS(TAPS)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .reseed   (start),
    .advance  (step_fire),
    .seed     (seed),
    .ref_sign (ref_sign)
  );

  nhv_product #(.N_BITS(N_BITS)) u_prod (
    .ref_sign (ref_sign),
    .str      (str_q),
    .sample   (tx_sample)
  );

  nhv_ctrl #(.CNT_W(CNT_W), .DEF_STEPS(DEF_STEPS)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .num_steps    (num_steps),
    .step_en      (step_en),
    .rx_sample    (rx_sample),
    .local_sample (tx_sample),
    .step_fire    (step_fire),
    .busy         (busy),
    .differ       (differ),
    .equal        (equal),
    .done         (done),
    .steps_done   (steps_done),
    .target       (target_q)
  );
endmodule

// File: rtl/nhv_checker.sv
module nhv_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic             busy,
  input logic             differ,
  input logic             equal,
  input logic             done,
  input logic             tx_sample,
  input logic [CNT_W-1:0] steps_done,
  input logic [CNT_W-1:0] target
);
  AST_START_ARMS: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && !differ && !equal && !done && (steps_done == '0)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R5

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R6

  AST_EQUAL_AT_TARGET: assert property (@(posedge clk) disable iff (rst)
    equal |-> (steps_done == target)); // R6

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(differ && equal)); // R7

  AST_DIFF_STICKY: assert property (@(posedge clk) disable iff (rst)
    differ && !start |=> differ); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> $stable(steps_done) && $stable(differ) && $stable(equal) && $stable(tx_sample)); // R8

  AST_TARGET_LIVE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (target != '0)); // R10
endmodule

bind noise_hash_verifier nhv_checker #(.CNT_W(CNT_W)) u_nhv_checker (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .differ     (differ),
  .equal      (equal),
  .done       (done),
  .tx_sample  (tx_sample),
  .steps_done (steps_done),
  .target     (target_q)
);

// File: tb/test_noise_hash_verifier.sv
`timescale 1ns/1ps
module test_noise_hash_verifier;
  localparam int N = 8;
  localparam int W = 16;
  localparam int C = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [N-1:0] loc_str = '0;
  logic [W-1:0] seed = '0;
  logic [C-1:0] num_steps = '0;
  logic         step_en = 1'b0;
  logic         rx_sample = 1'b0;
  logic         tx_sample, busy, differ, equal, done;
  logic [C-1:0] steps_done;

  always #4 clk = ~clk;

  noise_hash_verifier #(.N_BITS(N), .LFSR_W(W), .CNT_W(C)) i_noise_hash_verifier (
    .clk(clk), .rst(rst), .start(start), .loc_str(loc_str), .seed(seed),
    .num_steps(num_steps), .step_en(step_en), .rx_sample(rx_sample),
    .tx_sample(tx_sample), .busy(busy), .differ(differ), .equal(equal),
    .done(done), .steps_done(steps_done)
  );

  int nchecks = 0;
  int nerr = 0;

  // behavioural model
  int unsigned gen [2*N];
  logic [N-1:0] m_str, rstr;
  int m_cnt, m_tgt;
  bit m_busy, m_diff, m_eq, m_done;

  function automatic int unsigned seed_of(input int k, input int unsigned s);
    int unsigned v;
    v = (s ^ ((k + 1) * 32'h9E3779B9)) & 32'hFFFF;
    if (v == 0) v = 1;
    return v;
  endfunction

  function automatic int unsigned lfsr_step(input int unsigned v);
    int unsigned r;
    r = v >> 1;
    if (v[0]) r = r ^ 32'hB400;
    return r;
  endfunction

  function automatic bit msample(input logic [N-1:0] s);
    bit x;
    x = 0;
    for (int i = 0; i < N; i++) x = x ^ gen[2*i + int'(s[i])][0];
    return x;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_diff = 0; m_eq = 0; m_done = 0; m_cnt = 0;
      for (int k = 0; k < 2*N; k++) gen[k] = 1;
    end else begin
      m_done = 0;
      if (start) begin
        m_str = loc_str;
        m_tgt = (num_steps == 0) ? 83 : int'(num_steps);
        for (int k = 0; k < 2*N; k++) gen[k] = seed_of(k, seed);
        m_cnt = 0; m_diff = 0; m_eq = 0; m_busy = 1;
      end else if (m_busy && step_en) begin
        bit mis;
        mis = (rx_sample != msample(m_str));
        for (int k = 0; k < 2*N; k++) gen[k] = lfsr_step(gen[k]);
        m_cnt = (m_cnt + 1) % 256;
        if (mis) begin
          m_diff = 1; m_busy = 0; m_done = 1;
        end else if (m_cnt == m_tgt) begin
          m_eq = 1; m_busy = 0; m_done = 1;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("R2 busy", int'(busy), int'(m_busy));
    chk("R5 differ", int'(differ), int'(m_diff));
    chk("R6 equal", int'(equal), int'(m_eq));
    chk("R6 done", int'(done), int'(m_done));
    chk("R6 steps_done", int'(steps_done), m_cnt);
    if (m_busy) chk("R3 R4 tx_sample", int'(tx_sample), int'(msample(m_str)));
  endtask

  task automatic drive(input bit st, input bit se, input bit cor);
    start     = st;
    step_en   = se;
    rx_sample = msample(rstr) ^ cor;
    tick();
  endtask

  task automatic run_to_done();
    for (int c = 0; c < 300 && !done; c++) drive(0, 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    logic tx_hold;
    rstr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    chk("R1 busy", int'(busy), 0);
    chk("R1 differ", int'(differ), 0);
    chk("R1 equal", int'(equal), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 steps_done", int'(steps_done), 0);

    // default target, identical strings
    loc_str = 8'hA5; rstr = 8'hA5; seed = 16'h1234; num_steps = 0;
    drive(1, 0, 0);
    chk("R3 first sample", int'(tx_sample), int'(msample(8'hA5)));
    run_to_done();
    chk("R9 equal", int'(equal), 1);
    chk("R10 default steps", int'(steps_done), 83);

    // idle stimulus ignored
    tx_hold = tx_sample;
    for (int c = 0; c < 4; c++) drive(0, 1, c[0]);
    chk("R8 tx held", int'(tx_sample), int'(tx_hold));
    chk("R8 steps held", int'(steps_done), 83);
    chk("R8 equal held", int'(equal), 1);

    // one-bit difference
    rstr = 8'hA5 ^ 8'h10; num_steps = 83;
    drive(1, 0, 0);
    run_to_done();
    chk("R5 differ found", int'(differ), 1);
    chk("R7 equal clear", int'(equal), 0);
    for (int c = 0; c < 3; c++) drive(0, 1, 0);
    chk("R7 differ sticky", int'(differ), 1);

    // flipped sample at the third step
    rstr = 8'hA5; num_steps = 10; seed = 16'h0F0F;
    drive(1, 0, 0);
    drive(0, 1, 0);
    drive(0, 1, 0);
    drive(0, 1, 1);
    chk("R5 differ at step", int'(differ), 1);
    chk("R5 count at mismatch", int'(steps_done), 3);

    // single-step target
    loc_str = 8'h3C; rstr = 8'h3C; num_steps = 1;
    drive(1, 0, 0);
    drive(0, 1, 0);
    chk("R6 equal after one", int'(equal), 1);
    chk("R6 steps one", int'(steps_done), 1);

    // gaps in step_en
    num_steps = 5; seed = 16'hBEEF;
    drive(1, 0, 0);
    for (int c = 0; c < 30 && !done; c++) drive(0, (c % 3) != 0, 0);
    chk("R6 equal with gaps", int'(equal), 1);
    chk("R6 steps with gaps", int'(steps_done), 5);

    // restart during a run
    num_steps = 50; seed = 16'h0000;
    drive(1, 0, 0);
    for (int c = 0; c < 10; c++) drive(0, 1, 0);
    drive(1, 1, 0);
    chk("R2 restart count", int'(steps_done), 0);
    chk("R2 restart busy", int'(busy), 1);
    run_to_done();
    chk("R9 equal after restart", int'(equal), 1);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end
endmodule